// File: doc/BRIEF.md
# Trimmed-Mean Sample Averaging Filter

This block reduces a burst of 12-bit converter samples from one measurement channel to a single filtered code. Software or a sequencer selects a 3-bit averaging mode, pulses `start`, and then presents samples on `smp_data` with a one-cycle `smp_valid` strobe per sample. Gaps between strobes are allowed. Once the number of samples that the mode calls for has arrived, the block emits the filtered code on `avg_data` with a one-cycle `avg_valid` pulse.

The two smallest modes take one or two samples and average them directly. The four larger modes take 4, 6, 10 or 18 samples, keep a running sum, minimum and maximum, and subtract one smallest and one largest sample from the sum. The count that remains is always a power of two, so the division is a truncating right shift. The mode is captured at `start`. `clear` abandons a collection in progress without producing a result.

Top module: `trimmed_mean_filter`

## Requirements
- R1: Mode code 0 takes exactly one sample and outputs it unchanged.
- R2: Mode code 1 takes two samples and outputs their sum shifted right by one bit (truncated).
- R3: Mode code 2 takes four samples, subtracts the smallest and the largest from the sum, and outputs the remainder shifted right by one bit.
- R4: Mode code 3 takes six samples, removes one smallest and one largest, and outputs the remainder shifted right by two bits.
- R5: Mode code 4 takes ten samples, removes one smallest and one largest, and outputs the remainder shifted right by three bits.
- R6: Mode code 5 takes eighteen samples, removes one smallest and one largest, and outputs the remainder shifted right by four bits. The sum does not overflow even when every sample is 4095.
- R7: Mode codes 6 and 7 behave exactly like mode code 0.
- R8: When several samples share the smallest or the largest value, only one instance of each is removed.
- R9: `avg_valid` is high for exactly one cycle. That cycle is the one after the cycle in which the final sample's `smp_valid` was high. `avg_data` keeps its value until the next result.
- R10: Samples strobed while no collection is in progress are ignored: no `avg_valid`, and `avg_data` is unchanged.
- R11: `clear` ends any collection in progress without a result, and later samples are ignored until the next `start`. If `clear` and `start` are both high, `clear` wins.
- R12: `start` during a collection discards all samples gathered so far and begins a new collection with the mode then present. A sample strobed in the same cycle as `start` is not counted.
- R13: The mode is captured in the `start` cycle. Changes on `mode` during a collection do not affect it.
- R14: After reset, `avg_valid` is 0 and `avg_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Averaging mode code, captured on start |
| start | input | 1 | Begin a new collection |
| clear | input | 1 | Abandon the collection in progress |
| smp_valid | input | 1 | Sample strobe, one per sample |
| smp_data | input | 12 | Sample code |
| avg_valid | output | 1 | One-cycle pulse marking a new result |
| avg_data | output | 12 | Filtered result code |

## Verification
Assertions run on every cycle and cover the following. `avg_valid` only follows an accepted sample and never lasts two cycles. No result follows `clear`. The running sum never wraps. The trimmed sum never goes below zero. The running minimum never exceeds the running maximum. The captured mode stays put for the whole collection. The arithmetic itself can only be shown by the bench's scenarios. These cover the result of each mode, the full-scale eighteen-sample burst, repeated extreme values, idle strobes, aborting with clear, and restarting mid-burst.

// File: rtl/tmf_pkg.sv
package tmf_pkg;

    localparam int SAMPLE_W = 12;
    localparam int MODE_W   = 3;
    localparam int MAX_TAKE = 18;
    localparam int CNT_W    = $clog2(MAX_TAKE + 1);
    localparam int SHIFT_W  = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_SINGLE  = 3'd0,
        MODE_PAIR    = 3'd1,
        MODE_TRIM4   = 3'd2,
        MODE_TRIM6   = 3'd3,
        MODE_TRIM10  = 3'd4,
        MODE_TRIM18  = 3'd5
    } avg_mode_e;

    // How one collection is run: sample count, divide shift, min/max removal
    typedef struct packed {
        logic [CNT_W-1:0]   take;
        logic [SHIFT_W-1:0] shift;
        logic               trim;
    } frame_plan_t;

    function automatic frame_plan_t plan_for(input logic [MODE_W-1:0] code);
        frame_plan_t p;
        case (avg_mode_e'(code))
            MODE_PAIR:   p = '{take: CNT_W'(2),  shift: SHIFT_W'(1), trim: 1'b0};
            MODE_TRIM4:  p = '{take: CNT_W'(4),  shift: SHIFT_W'(1), trim: 1'b1};
            MODE_TRIM6:  p = '{take: CNT_W'(6),  shift: SHIFT_W'(2), trim: 1'b1};
            MODE_TRIM10: p = '{take: CNT_W'(10), shift: SHIFT_W'(3), trim: 1'b1};
            MODE_TRIM18: p = '{take: CNT_W'(18), shift: SHIFT_W'(4), trim: 1'b1};
            default:     p = '{take: CNT_W'(1),  shift: SHIFT_W'(0), trim: 1'b0};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/tmf_plan_latch.sv
module tmf_plan_latch
    import tmf_pkg::*;
#(
    parameter int MW = MODE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [MW-1:0] mode,
    output frame_plan_t   plan
);

    frame_plan_t plan_q;

    always_ff @(posedge clk) begin
        if (rst)
            plan_q <= plan_for('0);
        else if (start)
            plan_q <= plan_for(MODE_W'(mode));
    end

    assign plan = plan_q;

endmodule

// File: rtl/tmf_extrema.sv
module tmf_extrema #(
    parameter int DW = tmf_pkg::SAMPLE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          init,
    input  logic          accept,
    input  logic [DW-1:0] sample,
    output logic [DW-1:0] lo_next,
    output logic [DW-1:0] hi_next
);

    logic [DW-1:0] lo_q;
    logic [DW-1:0] hi_q;

    // Running extremes including the sample offered this cycle
    always_comb begin
        lo_next = (sample < lo_q) ? sample : lo_q;
        hi_next = (sample > hi_q) ? sample : hi_q;
    end

    always_ff @(posedge clk) begin
        if (rst || init) begin
            lo_q <= '1;
            hi_q <= '0;
        end else if (accept) begin
            lo_q <= lo_next;
            hi_q <= hi_next;
        end
    end

    // R8: once a sample is in, the kept minimum never exceeds the kept maximum
    assert_lo_le_hi_R8: assert property (@(posedge clk) disable iff (rst)
        (accept && !init) |=> (lo_q <= hi_q));

endmodule

// File: rtl/tmf_accum.sv
module tmf_accum #(
    parameter int DW    = tmf_pkg::SAMPLE_W,
    parameter int SW    = DW + $clog2(tmf_pkg::MAX_TAKE),
    parameter int CW    = tmf_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          init,
    input  logic          accept,
    input  logic [DW-1:0] sample,
    output logic [SW-1:0] sum_next,
    output logic [CW-1:0] cnt_next
);

    logic [SW-1:0] sum_q;
    logic [CW-1:0] cnt_q;

    assign sum_next = sum_q + SW'(sample);
    assign cnt_next = cnt_q + CW'(1);

    always_ff @(posedge clk) begin
        if (rst || init) begin
            sum_q <= '0;
            cnt_q <= '0;
        end else if (accept) begin
            sum_q <= sum_next;
            cnt_q <= cnt_next;
        end
    end

    // R6: adding a sample never wraps the accumulator
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        accept |-> (sum_next >= sum_q));

    // R6: the count never runs past the largest burst
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(tmf_pkg::MAX_TAKE));

endmodule

// File: rtl/trimmed_mean_filter.sv
module trimmed_mean_filter
    import tmf_pkg::*;
#(
    parameter int DATA_W = SAMPLE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    input  logic              start,
    input  logic              clear,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    output logic              avg_valid,
    output logic [DATA_W-1:0] avg_data
);

    localparam int SUM_W = DATA_W + $clog2(MAX_TAKE);

    frame_plan_t       plan;
    logic              busy_q;
    logic              init;
    logic              accept;
    logic              last;
    logic [SUM_W-1:0]  sum_next;
    logic [CNT_W-1:0]  cnt_next;
    logic [DATA_W-1:0] lo_next;
    logic [DATA_W-1:0] hi_next;
    logic [SUM_W-1:0]  kept_sum;
    logic [SUM_W-1:0]  scaled;
    logic              valid_q;
    logic [DATA_W-1:0] data_q;

    assign init   = start | clear;
    assign accept = busy_q & smp_valid & ~init;
    assign last   = accept & (cnt_next == plan.take);

    tmf_plan_latch #(.MW(MODE_W)) u_plan (
        .clk   (clk),
        .rst   (rst),
        .start (start & ~clear),
        .mode  (mode),
        .plan  (plan)
    );

    tmf_accum #(.DW(DATA_W), .SW(SUM_W), .CW(CNT_W)) u_accum (
        .clk      (clk),
        .rst      (rst),
        .init     (init),
        .accept   (accept),
        .sample   (smp_data),
        .sum_next (sum_next),
        .cnt_next (cnt_next)
    );

    tmf_extrema #(.DW(DATA_W)) u_ext (
        .clk     (clk),
        .rst     (rst),
        .init    (init),
        .accept  (accept),
        .sample  (smp_data),
        .lo_next (lo_next),
        .hi_next (hi_next)
    );

    always_comb begin
        if (plan.trim)
            kept_sum = sum_next - SUM_W'(lo_next) - SUM_W'(hi_next);
        else
            kept_sum = sum_next;
        scaled = kept_sum >> plan.shift;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= last;
            if (last)
                data_q <= scaled[DATA_W-1:0];
            if (clear)
                busy_q <= 1'b0;
            else if (start)
                busy_q <= 1'b1;
            else if (last)
                busy_q <= 1'b0;
        end
    end

    assign avg_valid = valid_q;
    assign avg_data  = data_q;

    // R9: a result only follows an accepted sample
    assert_valid_after_sample_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(avg_valid) |-> $past(smp_valid));

    // R9: the result strobe never lasts two cycles
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        avg_valid |=> !avg_valid);

    // R11: no result in the cycle after clear
    assert_clear_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        clear |=> !avg_valid);

    // R3: removing the extremes never drives the sum below zero
    assert_trim_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
        (last && plan.trim) |-> (sum_next >= (SUM_W'(lo_next) + SUM_W'(hi_next))));

    // R13: the captured plan is held through a collection
    assert_plan_held_R13: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !start) |=> $stable(plan));

endmodule

// File: tb/trimmed_mean_filter_test.sv
module trimmed_mean_filter_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  mode;
    logic        start;
    logic        clear;
    logic        smp_valid;
    logic [11:0] smp_data;
    logic        avg_valid;
    logic [11:0] avg_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int smp [0:17];

    always #10 clk = ~clk;

    trimmed_mean_filter uut (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .start     (start),
        .clear     (clear),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .avg_valid (avg_valid),
        .avg_data  (avg_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Mode table from the requirements: count, trim flag, shift
    function automatic int take_of(input int m);
        case (m)
            1: return 2;
            2: return 4;
            3: return 6;
            4: return 10;
            5: return 18;
            default: return 1;
        endcase
    endfunction

    function automatic int ref_avg(input int m);
        int n, s, lo, hi, sh;
        n = take_of(m);
        s = 0; lo = 4096; hi = -1;
        for (int i = 0; i < n; i++) begin
            s += smp[i];
            if (smp[i] < lo) lo = smp[i];
            if (smp[i] > hi) hi = smp[i];
        end
        case (m)
            1: sh = 1;
            2: sh = 1;
            3: sh = 2;
            4: sh = 3;
            5: sh = 4;
            default: sh = 0;
        endcase
        if (m >= 2 && m <= 5) s = s - lo - hi;
        return s >> sh;
    endfunction

    task automatic do_start(input int m);
        @(negedge clk);
        mode = 3'(m); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Feed one full burst from smp[] and check the pulse and value
    task automatic run_frame(input int m, input string req);
        int n;
        n = take_of(m);
        do_start(m);
        for (int i = 0; i < n; i++) begin
            smp_valid = 1'b1; smp_data = 12'(smp[i]);
            @(negedge clk);
            smp_valid = 1'b0;
            if (i < n - 1) chk({req, " no early result"}, int'(avg_valid), 0);
        end
        chk({req, " valid pulse"}, int'(avg_valid), 1);
        chk({req, " value"}, int'(avg_data), ref_avg(m));
        @(negedge clk);
        chk("R9 pulse ends", int'(avg_valid), 0);
        chk("R9 value held", int'(avg_data), ref_avg(m));
    endtask

    task automatic t_reset();
        chk("R14 reset valid", int'(avg_valid), 0);
        chk("R14 reset data", int'(avg_data), 0);
    endtask

    task automatic t_single();
        smp[0] = 12'hABC; run_frame(0, "R1 single");
        smp[0] = 77;      run_frame(6, "R7 code6");
        smp[0] = 4095;    run_frame(7, "R7 code7");
    endtask

    task automatic t_pair();
        smp[0] = 100; smp[1] = 201; run_frame(1, "R2 pair");
    endtask

    task automatic t_trim4();
        smp[0] = 50; smp[1] = 4000; smp[2] = 1; smp[3] = 60;
        run_frame(2, "R3 trim4");
        chk("R3 expected 55", ref_avg(2), 55);
    endtask

    task automatic t_dups();
        smp[0] = 10; smp[1] = 20; smp[2] = 10; smp[3] = 20;
        run_frame(2, "R8 dup extremes");
        for (int i = 0; i < 6; i++) smp[i] = 900;
        smp[2] = 100; smp[4] = 100;
        run_frame(3, "R8 dup min six");
    endtask

    task automatic t_trim6();
        smp[0] = 300; smp[1] = 100; smp[2] = 3000;
        smp[3] = 200; smp[4] = 500; smp[5] = 400;
        run_frame(3, "R4 trim6");
    endtask

    task automatic t_trim10();
        for (int i = 0; i < 10; i++) smp[i] = (i * 397 + 13) % 4096;
        run_frame(4, "R5 trim10");
    endtask

    task automatic t_trim18();
        for (int i = 0; i < 18; i++) smp[i] = 4095;
        run_frame(5, "R6 full scale");
        for (int i = 0; i < 18; i++) smp[i] = (i * 611 + 29) % 4096;
        run_frame(5, "R6 mixed");
    endtask

    task automatic t_idle();
        int held;
        held = int'(avg_data);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            smp_valid = 1'b1; smp_data = 12'(i * 1000 + 5);
            @(negedge clk);
            smp_valid = 1'b0;
            chk("R10 idle no valid", int'(avg_valid), 0);
        end
        chk("R10 idle data kept", int'(avg_data), held);
    endtask

    task automatic t_clear();
        int held;
        held = int'(avg_data);
        do_start(2);
        for (int i = 0; i < 3; i++) begin
            smp_valid = 1'b1; smp_data = 12'(700 + i);
            @(negedge clk);
        end
        smp_valid = 1'b0; clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        chk("R11 no result on clear", int'(avg_valid), 0);
        smp_valid = 1'b1; smp_data = 12'd3;
        @(negedge clk);
        smp_valid = 1'b0;
        chk("R11 later sample ignored", int'(avg_valid), 0);
        chk("R11 data kept", int'(avg_data), held);
        // clear beats start in the same cycle
        @(negedge clk);
        mode = 3'd0; start = 1'b1; clear = 1'b1;
        @(negedge clk);
        start = 1'b0; clear = 1'b0;
        smp_valid = 1'b1; smp_data = 12'd9;
        @(negedge clk);
        smp_valid = 1'b0;
        chk("R11 clear wins over start", int'(avg_valid), 0);
    endtask

    task automatic t_restart();
        do_start(2);
        for (int i = 0; i < 2; i++) begin
            smp_valid = 1'b1; smp_data = 12'd4000;
            @(negedge clk);
        end
        // restart with a sample in the start cycle: that sample is dropped
        mode = 3'd1; start = 1'b1; smp_valid = 1'b1; smp_data = 12'd4095;
        @(negedge clk);
        start = 1'b0;
        smp_data = 12'd10;
        @(negedge clk);
        chk("R12 restart no early result", int'(avg_valid), 0);
        smp_data = 12'd20;
        @(negedge clk);
        smp_valid = 1'b0;
        chk("R12 restart valid", int'(avg_valid), 1);
        chk("R12 restart value", int'(avg_data), 15);
    endtask

    task automatic t_mode_hold();
        do_start(1);
        mode = 3'd0;
        smp_valid = 1'b1; smp_data = 12'd40;
        @(negedge clk);
        chk("R13 mode change ignored", int'(avg_valid), 0);
        mode = 3'd5;
        smp_data = 12'd61;
        @(negedge clk);
        smp_valid = 1'b0;
        chk("R13 captured mode valid", int'(avg_valid), 1);
        chk("R13 captured mode value", int'(avg_data), 50);
    endtask

    initial begin
        rst = 1'b1; mode = '0; start = 1'b0; clear = 1'b0;
        smp_valid = 1'b0; smp_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle();
        t_single();
        t_pair();
        t_trim4();
        t_trim6();
        t_trim10();
        t_trim18();
        t_dups();
        t_clear();
        t_restart();
        t_mode_hold();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule